// File: doc/BRIEF.md
# Nested-Loop Add-Accumulate Engine

This block runs one fixed two-level loop on three operands of parameter width `W` (8 bits by default). A run starts when the block is idle and `start` is high. On that edge the block copies `x_in` into an accumulator and `y_in` and `z_in` into two loadable up-counters. It then adds the inner counter into the accumulator and steps the inner counter. The top bit of the inner counter decides whether the inner loop runs again. When the inner loop exits, the outer counter is stepped and its top bit decides whether control goes back to the add step. When both loops have exited, the accumulator is copied to a held result register and `done` rises.

Each loop test and the matching counter step happen in the same cycle. The branch therefore sees the counter value from before the step. All arithmetic wraps modulo 2^W.

The input side follows a valid/ready rule. `start` acts as the valid and `in_ready` as the ready, and a run is accepted only on an edge where both are high. While a run is in progress `in_ready` is low, and `start` together with the operand inputs is ignored. Back-pressure is therefore simply the length of the run. The result is not a stream: `u_out` and `done` are held levels that stay valid until the next run is accepted.

Top module: `nloop_accum`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and `u_out` is 0.
- R2: While idle with `start` low, `in_ready` stays 1 and `u_out` and `done` do not change.
- R3: On an edge where `in_ready` and `start` are both 1, the operands are captured and, from the next cycle on, `in_ready` and `done` read 0.
- R4: The result equals the algorithm applied to the captured operands: A=X, B=Y, C=Z; repeat { repeat { A=A+B; t=B[W-1]; B=B+1 } until t; t=C[W-1]; C=C+1 } until t; U=A.
- R5: The inner exit test uses the value of B before that cycle's increment. For example, with W=8 and Y=127, the inner loop runs twice.
- R6: The outer exit test uses the value of C before that cycle's increment.
- R7: Counting the accept edge as 1, `done` is first seen high after exactly 2 + 2·(adds) + (outer tests) edges.
- R8: After a run, `done` stays 1 and `u_out` holds its value while idle, until the next run is accepted.
- R9: A `start` pulse or operand change while `in_ready` is 0 has no effect on the running result.
- R10: Sums and counter steps wrap modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a run (valid) |
| in_ready | output | 1 | High when idle and able to accept a run |
| x_in | input | W | Initial accumulator value |
| y_in | input | W | Initial inner-loop counter value |
| z_in | input | W | Initial outer-loop counter value |
| u_out | output | W | Held result of the last finished run |
| done | output | 1 | High from the end of a run until the next accept |

## Verification
The assertions assume that `start` is only meaningful while `in_ready` is high. They also assume the operand inputs need to be valid only on the accept edge, so nothing is checked about them in other cycles. The stimulus drives inputs on the falling edge, so the accept edge sees stable values. It pulses `start` with different operands in the middle of some runs to show they are ignored. A 4-bit instance is swept over every inner and outer counter start value. An 8-bit instance covers the boundary values around the sign bit, plus pseudo-random operands.

// File: rtl/nloop_accum_pkg.sv
package nloop_accum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADD  = 3'd1,
    ST_TSTB = 3'd2,
    ST_TSTC = 3'd3,
    ST_OUT  = 3'd4
  } nla_state_e;

  typedef struct packed {
    logic ld_a;     // write accumulator
    logic sel_sum;  // 1: adder result, 0: x operand
    logic ld_b;     // load inner counter
    logic inc_b;    // step inner counter
    logic ld_c;     // load outer counter
    logic inc_c;    // step outer counter
    logic ld_u;     // capture result
  } nla_ctrl_t;

endpackage

// File: rtl/nla_counter.sv
module nla_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         msb
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= d;
    end else if (inc) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign q   = cnt_q;
  assign msb = cnt_q[W-1];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> cnt_q == W'($past(cnt_q) + ONE)); // R10

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/nla_datapath.sv
module nla_datapath
  import nloop_accum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  nla_ctrl_t    ctl,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] z_in,
  output logic         b_msb,
  output logic         c_msb,
  output logic [W-1:0] u_out
);

  logic [W-1:0] a_q;
  logic [W-1:0] b_val;
  logic [W-1:0] c_val;
  logic [W-1:0] sum;
  logic [W-1:0] a_next;
  logic [W-1:0] u_q;

  // adder and accumulator input mux
  assign sum    = a_q + b_val;
  assign a_next = ctl.sel_sum ? sum : x_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (ctl.ld_a) begin
      a_q <= a_next;
    end
  end

  nla_counter #(.W(W)) b_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ctl.ld_b),
    .inc   (ctl.inc_b),
    .d     (y_in),
    .q     (b_val),
    .msb   (b_msb)
  );

  nla_counter #(.W(W)) c_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ctl.ld_c),
    .inc   (ctl.inc_c),
    .d     (z_in),
    .q     (c_val),
    .msb   (c_msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q <= '0;
    end else if (ctl.ld_u) begin
      u_q <= a_q;
    end
  end

  assign u_out = u_q;

  AST_ACC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ld_a && ctl.sel_sum) |=> a_q == W'($past(a_q) + $past(b_val))); // R4

  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ld_a && !ctl.sel_sum) |=> a_q == $past(x_in)); // R3

  AST_U_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld_u |=> $stable(u_q)); // R8

endmodule

// File: rtl/nla_ctrl.sv
module nla_ctrl
  import nloop_accum_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      b_msb,
  input  logic      c_msb,
  output nla_ctrl_t ctl,
  output logic      idle,
  output logic      done
);

  nla_state_e state_q;
  nla_state_e state_d;
  logic       done_q;
  logic       done_d;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    ctl     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ctl.ld_a    = 1'b1;
          ctl.sel_sum = 1'b0;
          ctl.ld_b    = 1'b1;
          ctl.ld_c    = 1'b1;
          done_d      = 1'b0;
          state_d     = ST_ADD;
        end
      end
      ST_ADD: begin
        ctl.ld_a    = 1'b1;
        ctl.sel_sum = 1'b1;
        state_d     = ST_TSTB;
      end
      ST_TSTB: begin
        // test uses the counter value before this edge's step
        ctl.inc_b = 1'b1;
        state_d   = b_msb ? ST_TSTC : ST_ADD;
      end
      ST_TSTC: begin
        ctl.inc_c = 1'b1;
        state_d   = c_msb ? ST_OUT : ST_ADD;
      end
      ST_OUT: begin
        ctl.ld_u = 1'b1;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign done = done_q;

  AST_ACCEPT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (!done_q && state_q == ST_ADD)); // R3

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (!ctl.ld_b && !ctl.ld_c && !(ctl.ld_a && !ctl.sel_sum))); // R9

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.inc_b, ctl.inc_c, ctl.ld_u, ctl.sel_sum})); // R6

  AST_INNER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TSTB && !b_msb) |=> state_q == ST_ADD); // R5

  AST_OUTER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TSTC && !c_msb) |=> state_q == ST_ADD); // R6

  AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OUT) |=> (done_q && idle)); // R8

endmodule

// File: rtl/nloop_accum.sv
module nloop_accum
  import nloop_accum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         in_ready,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] z_in,
  output logic [W-1:0] u_out,
  output logic         done
);

  nla_ctrl_t ctl;
  logic      b_msb;
  logic      c_msb;
  logic      idle;

  nla_ctrl ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .b_msb (b_msb),
    .c_msb (c_msb),
    .ctl   (ctl),
    .idle  (idle),
    .done  (done)
  );

  nla_datapath #(.W(W)) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .x_in  (x_in),
    .y_in  (y_in),
    .z_in  (z_in),
    .b_msb (b_msb),
    .c_msb (c_msb),
    .u_out (u_out)
  );

  assign in_ready = idle;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !start) |=> (in_ready && $stable(u_out) && $stable(done))); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && start) |=> (!in_ready && !done)); // R3

endmodule

// File: tb/nloop_accum_tb_top.sv
module nloop_accum_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st8 = 1'b0, st4 = 1'b0;
  logic       rdy8, rdy4, dn8, dn4;
  logic [7:0] x8 = '0, y8 = '0, z8 = '0, u8;
  logic [3:0] x4 = '0, y4 = '0, z4 = '0, u4;

  int n_checks = 0;
  int n_errors = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  nloop_accum #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(st8), .in_ready(rdy8),
    .x_in(x8), .y_in(y8), .z_in(z8), .u_out(u8), .done(dn8));

  nloop_accum #(.W(4)) dut_w4_i (
    .clk(clk), .rst_n(rst_n), .start(st4), .in_ready(rdy4),
    .x_in(x4), .y_in(y4), .z_in(z4), .u_out(u4), .done(dn4));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // algorithm from R4, cycle rule from R7
  function automatic void ref_run(input int w, input int x, input int y, input int z,
                                  output int u, output int cyc);
    int m = (1 << w) - 1;
    int a = x;
    int b = y;
    int c = z;
    int t;
    cyc = 2;
    do begin
      do begin
        a = (a + b) & m;
        t = (b >> (w - 1)) & 1;
        b = (b + 1) & m;
        cyc += 2;
      end while (t == 0);
      t = (c >> (w - 1)) & 1;
      c = (c + 1) & m;
      cyc += 1;
    end while (t == 0);
    u = a;
  endfunction

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 190000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic run_case(input bit sm, input int x, input int y, input int z,
                          input bit poke, input string tag);
    int exp_u, exp_c, cyc, u_got;
    bit d;
    ref_run(sm ? 4 : 8, x, y, z, exp_u, exp_c);
    @(negedge clk);
    if (sm) begin x4 = 4'(x); y4 = 4'(y); z4 = 4'(z); st4 = 1'b1; end
    else    begin x8 = 8'(x); y8 = 8'(y); z8 = 8'(z); st8 = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    cyc = 1;
    // R3: busy and done cleared after accept
    chk((sm ? rdy4 : rdy8) == 1'b0 && (sm ? dn4 : dn8) == 1'b0, {"R3 ", tag},
        sm ? int'(rdy4) : int'(rdy8), 0);
    if (poke) begin
      // R9: start with other operands while busy
      if (sm) begin x4 = ~x4; y4 = y4 ^ 4'h5; z4 = z4 ^ 4'h3; end
      else    begin x8 = ~x8; y8 = y8 ^ 8'h55; z8 = z8 ^ 8'h33; end
    end else begin
      st4 = 1'b0; st8 = 1'b0;
    end
    d = 1'b0;
    while (!d && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      st4 = 1'b0; st8 = 1'b0;
      d = sm ? dn4 : dn8;
    end
    u_got = sm ? int'(u4) : int'(u8);
    chk(u_got == exp_u, poke ? {"R9 ", tag} : {"R4 R10 ", tag}, u_got, exp_u);
    chk(cyc == exp_c, {"R7 R5 R6 ", tag}, cyc, exp_c);
  endtask

  initial begin
    int su, sc, lcg;
    repeat (3) @(negedge clk);
    // R1
    chk(rdy8 == 1'b1 && dn8 == 1'b0 && u8 == 8'd0, "R1 w8", int'(u8) + int'(dn8), 0);
    chk(rdy4 == 1'b1 && dn4 == 1'b0 && u4 == 4'd0, "R1 w4", int'(u4) + int'(dn4), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: idle without start
    chk(rdy8 == 1'b1 && dn8 == 1'b0 && u8 == 8'd0, "R2 idle", int'(u8), 0);

    // R5/R6 boundary: Y=127, Z=127 => two inner passes, result x+128
    run_case(1'b0, 3, 127, 127, 1'b0, "y127 z127");
    chk(u8 == 8'd131, "R5 inner pre-increment", int'(u8), 131);
    run_case(1'b0, 0, 128, 128, 1'b0, "y128 z128");
    chk(u8 == 8'd128, "R6 outer pre-increment", int'(u8), 128);
    run_case(1'b0, 255, 255, 255, 1'b0, "all ones");
    run_case(1'b0, 0, 0, 0, 1'b0, "all zero");
    run_case(1'b0, 17, 200, 5, 1'b1, "poke busy");

    // R8: hold after run
    su = u8;
    repeat (6) @(negedge clk);
    chk(dn8 == 1'b1 && int'(u8) == su && rdy8 == 1'b1, "R8 hold", int'(u8), su);

    lcg = 12345;
    for (int i = 0; i < 14; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      run_case(1'b0, (lcg >> 3) & 255, (lcg >> 11) & 255, (lcg >> 19) & 255, i[0], "random");
    end

    // near-exhaustive sweep of the 4-bit instance
    for (int y = 0; y < 16; y++) begin
      for (int z = 0; z < 16; z++) begin
        run_case(1'b1, (y * 3 + z) & 15, y, z, (y == z), "sweep w4");
      end
    end
    ref_run(4, 9, 15, 15, su, sc);
    run_case(1'b1, 9, 15, 15, 1'b0, "w4 wrap R10");
    chk(int'(u4) == su, "R10 wrap w4", int'(u4), su);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule